// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

A single DMA channel that copies bytes or 16-bit words from a source address to a destination address over a simple memory bus. A 64-bit configuration descriptor is latched when the channel is armed. The descriptor gives both start addresses, the transfer count, the unit size, the transfer mode, the trigger source, the per-side address step, the interrupt enable, the count-mask option and a bus priority. The priority is passed out to an external arbiter.

A chosen trigger starts the work while the channel is armed. The trigger is either the software request input or one line of a trigger pulse vector. Single modes move one unit per trigger, and block modes move the whole count per trigger. The repeated variants reload the descriptor addresses and stay armed when the count completes. The count can be fixed or taken from the first transferred byte plus an offset, with the descriptor length as a ceiling.

Top module: `dma_chan_engine`

## Requirements
- R1: On `arm_i` while idle, the channel latches `desc_i` and sets `armed_o`. The descriptor fields, from bit 63 down, are: source address[63:48], destination address[47:32], length mode[31:29], length[28:16], unit size[15], mode[14:13], trigger select[12:8], source step[7:6], destination step[5:4], interrupt enable[3], count mask[2] and priority[1:0]. The priority appears on `bus_prio_o`.
- R2: With length mode 0, or any value from 5 to 7, the channel moves exactly `length` units per completed job.
- R3: With length mode 1, 2, 3 or 4, the count is the first byte read plus 1, plus 0, plus 2 or plus 3 respectively, capped at `length`. At least one unit is always moved once the first unit is read.
- R4: With count mask 1, only the low 7 bits of the first byte enter the count. With count mask 0, all 8 bits do.
- R5: Unit size 0 moves one byte per transfer with `bus_word_o`=0. Unit size 1 moves a 16-bit word with `bus_word_o`=1.
- R6: After each unit, each address steps by its code: 0 leaves it unchanged, 1 adds one unit, 2 adds two units and 3 subtracts one unit, where a unit is 1 or 2 bytes. Addresses wrap modulo 65536.
- R7: Mode bit 13 = 0 (single) moves one unit per trigger. Mode bit 13 = 1 (block) moves the remaining count per trigger.
- R8: Mode bit 14 = 1 (repeated) keeps the channel armed after the count completes and reloads both start addresses. Mode bit 14 = 0 clears `armed_o` in the same cycle that `done_o` rises.
- R9: Trigger select 0 starts a transfer from `sw_req_i`. Any other value k starts it from `trig_vec_i[k]`, so select 1 is the previous-channel completion line. Lines that are not selected have no effect.
- R10: A trigger that arrives while the channel is not armed causes no bus cycle.
- R11: A job whose count (or cap) is zero raises `done_o` without any bus cycle.
- R12: `done_o` pulses for one cycle when a job completes. `irq_o` pulses with it only when the interrupt enable bit is 1.
- R13: Each unit is a read cycle (`bus_rd_o`, source address) followed by a write cycle (`bus_wr_o`, destination address). The write carries the `bus_rdata_i` returned one cycle after the read. Read and write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Latch descriptor and arm (accepted while idle) |
| desc_i | input | 64 | Configuration descriptor |
| sw_req_i | input | 1 | Software transfer request |
| trig_vec_i | input | TRIG_W | Trigger pulse lines |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_word_o | output | 1 | Access is a 16-bit word |
| bus_addr_o | output | 16 | Byte address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid the cycle after a read |
| bus_prio_o | output | 2 | Priority for the external arbiter |
| armed_o | output | 1 | Channel is armed |
| done_o | output | 1 | Job complete pulse |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench sweeps every combination of unit size, source step and destination step in block mode and compares the whole memory against an arithmetic model. A wrong step code or a wrong unit scale would corrupt or misplace destination bytes. The variable-length sweep covers all four offsets, both mask settings, first bytes with bit 7 set and clear, a cap below the computed count, and the count-of-zero first byte. A miscounting design would show a different write total. Further runs cover address wrap at 0xFFFF, zero-length jobs that must finish with no bus traffic, triggers on unselected lines or while disarmed, the address reload in repeated mode, and interrupt masking.

// File: rtl/dma_pkg.sv
package dma_pkg;
   localparam int ADDR_W = 16;
   localparam int LEN_W  = 13;

   typedef struct packed {
      logic [ADDR_W-1:0] src;
      logic [ADDR_W-1:0] dst;
      logic [2:0]        vlen;
      logic [LEN_W-1:0]  len;
      logic              wsize;
      logic [1:0]        tmode;   // [0] block, [1] repeated
      logic [4:0]        trig;
      logic [1:0]        sinc;
      logic [1:0]        dinc;
      logic              irq_en;
      logic              m8;
      logic [1:0]        prio;
   } dma_desc_t;

   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_st_e;

   function automatic logic is_var_len(input logic [2:0] v);
      return (v >= 3'd1) && (v <= 3'd4);
   endfunction
endpackage

// File: rtl/dma_len_calc.sv
module dma_len_calc #(
   parameter int LEN_W = 13
) (
   input  logic [7:0]       first_i,
   input  logic [2:0]       vlen_i,
   input  logic             m8_i,
   input  logic [LEN_W-1:0] cap_i,
   output logic [LEN_W-1:0] count_o
);
   localparam int VC_W = 9;

   if (LEN_W < VC_W) begin : g_bad_len
      $error("dma_len_calc: LEN_W must be at least 9");
   end

   logic [VC_W-1:0]  base, calc;
   logic [LEN_W-1:0] wide;

   always_comb begin
      base = m8_i ? {2'b00, first_i[6:0]} : {1'b0, first_i};
      case (vlen_i)
         3'd1:    calc = base + 9'd1;
         3'd3:    calc = base + 9'd2;
         3'd4:    calc = base + 9'd3;
         default: calc = base;
      endcase
      wide    = LEN_W'(calc);
      count_o = (wide < cap_i) ? wide : cap_i;
   end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        inc_i,
   input  logic              wsize_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] unit;

   always_comb begin
      unit = wsize_i ? ADDR_W'(2) : ADDR_W'(1);
      case (inc_i)
         2'd0:    addr_o = addr_i;
         2'd1:    addr_o = addr_i + unit;
         2'd2:    addr_o = addr_i + (unit << 1);
         default: addr_o = addr_i - unit;
      endcase
   end
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
   parameter int TRIG_W = 32
) (
   input  logic [4:0]        sel_i,
   input  logic              sw_req_i,
   input  logic [TRIG_W-1:0] vec_i,
   output logic              fire_o
);
   logic [31:0] lines;

   if (TRIG_W == 32) begin : g_full
      assign lines = vec_i;
   end else begin : g_pad
      assign lines = {{(32-TRIG_W){1'b0}}, vec_i};
   end

   assign fire_o = (sel_i == 5'd0) ? sw_req_i : lines[sel_i];
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_pkg::*;
#(
   parameter int TRIG_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm_i,
   input  logic [63:0]         desc_i,
   input  logic                sw_req_i,
   input  logic [TRIG_W-1:0]   trig_vec_i,
   output logic                bus_rd_o,
   output logic                bus_wr_o,
   output logic                bus_word_o,
   output logic [ADDR_W-1:0]   bus_addr_o,
   output logic [15:0]         bus_wdata_o,
   input  logic [15:0]         bus_rdata_i,
   output logic [1:0]          bus_prio_o,
   output logic                armed_o,
   output logic                done_o,
   output logic                irq_o
);
   localparam int SIDES = 2;   // 0 = source, 1 = destination

   if (TRIG_W < 2 || TRIG_W > 32) begin : g_bad_trig
      $error("dma_chan_engine: TRIG_W must lie in 2..32");
   end
   if ($bits(dma_desc_t) != 64) begin : g_bad_desc
      $error("dma_chan_engine: descriptor must be 64 bits");
   end

   dma_desc_t                    desc_w, cfg_q;
   dma_st_e                      state_q;
   logic                         armed_q, known_q, done_q, irq_q;
   logic [LEN_W-1:0]             cnt_q, total_q, cnt_inc, var_cnt, tot_eff;
   logic [SIDES-1:0][ADDR_W-1:0] addr_q, addr_nx;
   logic                         fire, accept, last, fin;

   assign desc_w = dma_desc_t'(desc_i);

   dma_trig_sel #(.TRIG_W(TRIG_W)) u_trig (
      .sel_i    (cfg_q.trig),
      .sw_req_i (sw_req_i),
      .vec_i    (trig_vec_i),
      .fire_o   (fire)
   );

   dma_len_calc #(.LEN_W(LEN_W)) u_len (
      .first_i  (bus_rdata_i[7:0]),
      .vlen_i   (cfg_q.vlen),
      .m8_i     (cfg_q.m8),
      .cap_i    (total_q),
      .count_o  (var_cnt)
   );

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
         .addr_i   (addr_q[s]),
         .inc_i    ((s == 0) ? cfg_q.sinc : cfg_q.dinc),
         .wsize_i  (cfg_q.wsize),
         .addr_o   (addr_nx[s])
      );
   end

   always_comb begin
      cnt_inc = cnt_q + LEN_W'(1);
      tot_eff = known_q ? total_q : var_cnt;
      last    = (cnt_inc >= tot_eff);
      accept  = (state_q == ST_IDLE) && armed_q && !arm_i && fire;
      fin     = (accept && (total_q == '0)) || ((state_q == ST_WR) && last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
         armed_q <= 1'b0;
         known_q <= 1'b0;
         done_q  <= 1'b0;
         irq_q   <= 1'b0;
         cnt_q   <= '0;
         total_q <= '0;
         addr_q  <= '0;
      end else begin
         done_q <= fin;
         irq_q  <= fin & cfg_q.irq_en;
         case (state_q)
            ST_IDLE: begin
               if (arm_i) begin
                  cfg_q     <= desc_w;
                  armed_q   <= 1'b1;
                  cnt_q     <= '0;
                  total_q   <= desc_w.len;
                  known_q   <= !is_var_len(desc_w.vlen);
                  addr_q[0] <= desc_w.src;
                  addr_q[1] <= desc_w.dst;
               end else if (accept && (total_q != '0)) begin
                  state_q <= ST_RD;
               end
            end
            ST_RD: state_q <= ST_WR;
            ST_WR: begin
               addr_q  <= addr_nx;
               known_q <= 1'b1;
               total_q <= tot_eff;
               cnt_q   <= cnt_inc;
               state_q <= (cfg_q.tmode[0] && !last) ? ST_RD : ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (fin) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            if (cfg_q.tmode[1]) begin
               addr_q[0] <= cfg_q.src;
               addr_q[1] <= cfg_q.dst;
               total_q   <= cfg_q.len;
               known_q   <= !is_var_len(cfg_q.vlen);
            end else begin
               armed_q <= 1'b0;
            end
         end
      end
   end

   assign bus_rd_o    = (state_q == ST_RD);
   assign bus_wr_o    = (state_q == ST_WR);
   assign bus_addr_o  = (state_q == ST_RD) ? addr_q[0] : addr_q[1];
   assign bus_wdata_o = (state_q == ST_WR) ? bus_rdata_i : 16'h0000;
   assign bus_word_o  = cfg_q.wsize;
   assign bus_prio_o  = cfg_q.prio;
   assign armed_o     = armed_q;
   assign done_o      = done_q;
   assign irq_o       = irq_q;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic armed,
   input logic done,
   input logic irq,
   input logic rd,
   input logic wr,
   input logic rep
);
   a_r13_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && wr));
   a_r13_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> wr);
   a_r10_rd_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> armed);
   a_r12_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);
   a_r8_one_shot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rep) |-> !armed);
   a_r8_repeat_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rep) |-> armed);
endmodule

bind dma_chan_engine dma_chan_engine_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .armed (armed_o),
   .done  (done_o),
   .irq   (irq_o),
   .rd    (bus_rd_o),
   .wr    (bus_wr_o),
   .rep   (cfg_q.tmode[1])
);

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_N      = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm_i = 1'b0;
   logic [63:0] desc_i = '0;
   logic        sw_req_i = 1'b0;
   logic [31:0] trig_vec_i = '0;
   logic        bus_rd_o, bus_wr_o, bus_word_o;
   logic [15:0] bus_addr_o, bus_wdata_o;
   logic [15:0] bus_rdata_i = '0;
   logic [1:0]  bus_prio_o;
   logic        armed_o, done_o, irq_o;

   int passed = 0, total = 0, cycles = 0;
   int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, irq_cnt = 0;
   logic [15:0] last_wr_addr = '0;
   logic [15:0] rd_log [2];
   logic [7:0]  mem [MEM_N];
   logic [7:0]  expm [MEM_N];

   dma_chan_engine #(.TRIG_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .desc_i(desc_i),
      .sw_req_i(sw_req_i), .trig_vec_i(trig_vec_i),
      .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_word_o(bus_word_o),
      .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
      .bus_prio_o(bus_prio_o), .armed_o(armed_o), .done_o(done_o), .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (bus_rd_o) begin
         bus_rdata_i <= {mem[(int'(bus_addr_o) + 1) % MEM_N], mem[int'(bus_addr_o) % MEM_N]};
         if (rd_cnt < 2) rd_log[rd_cnt] <= bus_addr_o;
         rd_cnt <= rd_cnt + 1;
      end
      if (bus_wr_o) begin
         mem[int'(bus_addr_o) % MEM_N] <= bus_wdata_o[7:0];
         if (bus_word_o) mem[(int'(bus_addr_o) + 1) % MEM_N] <= bus_wdata_o[15:8];
         last_wr_addr <= bus_addr_o;
         wr_cnt <= wr_cnt + 1;
      end
      if (done_o) done_cnt <= done_cnt + 1;
      if (irq_o)  irq_cnt  <= irq_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (ok) passed++;
      else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
   endtask

   always @(posedge clk) begin
      if (cycles > 150000) begin
         total++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", passed, total);
         $finish;
      end
   end

   function automatic logic [63:0] mk(input logic [15:0] src, input logic [15:0] dst,
      input logic [2:0] vlen, input logic [12:0] len, input logic ws, input logic [1:0] tm,
      input logic [4:0] trig, input logic [1:0] si, input logic [1:0] di,
      input logic ie, input logic m8, input logic [1:0] pr);
      return {src, dst, vlen, len, ws, tm, trig, si, di, ie, m8, pr};
   endfunction

   function automatic logic [15:0] step(input logic [15:0] a, input int inc, input int ws);
      int u = ws ? 2 : 1;
      case (inc)
         0: return a;
         1: return a + 16'(u);
         2: return a + 16'(2*u);
         default: return a - 16'(u);
      endcase
   endfunction

   task automatic init_mem();
      for (int i = 0; i < MEM_N; i++) begin
         mem[i]  = (i < 512) ? 8'(i*7 + 3) : 8'h00;
         expm[i] = mem[i];
      end
   endtask

   task automatic arm(input logic [63:0] d);
      @(negedge clk); desc_i = d; arm_i = 1'b1;
      @(negedge clk); arm_i = 1'b0;
   endtask

   task automatic pulse_sw();
      @(negedge clk); sw_req_i = 1'b1;
      @(negedge clk); sw_req_i = 1'b0;
   endtask

   task automatic pulse_line(input int k);
      @(negedge clk); trig_vec_i[k] = 1'b1;
      @(negedge clk); trig_vec_i[k] = 1'b0;
   endtask

   task automatic wait_done(input int start);
      for (int i = 0; i < 3000 && done_cnt == start; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int d0, w0, r0, i0, mism, n, base, calc, offs;
      logic [15:0] s, d;
      logic [7:0] fb;
      init_mem();
      idle(3);
      check(!armed_o && !bus_rd_o && !bus_wr_o && !done_o && !irq_o, "R1",
            "reset outputs idle", {armed_o, bus_rd_o, bus_wr_o, done_o, irq_o}, 0);
      rst_n = 1'b1;
      idle(2);

      // R5 R6 R2 R13: block sweep over unit size and both step codes
      for (int ws = 0; ws < 2; ws++)
         for (int si = 0; si < 4; si++)
            for (int di = 0; di < 4; di++) begin
               init_mem();
               s = 16'h0080; d = 16'h0240;
               for (int i = 0; i < 3; i++) begin
                  for (int b = 0; b <= ws; b++)
                     expm[(int'(d) + b) % MEM_N] = expm[(int'(s) + b) % MEM_N];
                  s = step(s, si, ws); d = step(d, di, ws);
               end
               r0 = rd_cnt; d0 = done_cnt;
               arm(mk(16'h0080, 16'h0240, 3'd0, 13'd3, 1'(ws), 2'd1, 5'd0,
                      2'(si), 2'(di), 1'b0, 1'b0, 2'(si)));
               check(bus_word_o == 1'(ws), "R5", "unit size strobe", bus_word_o, ws);
               pulse_sw();
               wait_done(d0);
               mism = 0;
               for (int i = 0; i < MEM_N; i++) if (mem[i] !== expm[i]) mism++;
               check(mism == 0, "R6", $sformatf("memory ws%0d si%0d di%0d", ws, si, di), mism, 0);
               check(rd_cnt - r0 == 3, "R2", "fixed count reads", rd_cnt - r0, 3);
            end
      check(bus_prio_o == 2'd3, "R1", "priority field", bus_prio_o, 3);

      // R3 R4: variable length sweep
      for (int v = 1; v <= 4; v++)
         for (int m = 0; m < 2; m++)
            for (int k = 0; k < 2; k++) begin
               init_mem();
               fb = k ? 8'h80 : 8'h05;
               mem[16'h080] = fb;
               offs = (v == 1) ? 1 : (v == 2) ? 0 : (v == 3) ? 2 : 3;
               base = m ? int'(fb & 8'h7F) : int'(fb);
               calc = base + offs;
               n = (calc < 300) ? calc : 300;
               if (n < 1) n = 1;
               w0 = wr_cnt; d0 = done_cnt;
               arm(mk(16'h0080, 16'h0240, 3'(v), 13'd300, 1'b0, 2'd1, 5'd0,
                      2'd1, 2'd1, 1'b0, 1'(m), 2'd0));
               pulse_sw();
               wait_done(d0);
               check(wr_cnt - w0 == n, m ? "R4" : "R3",
                     $sformatf("vlen%0d m8=%0d first=%0h", v, m, fb), wr_cnt - w0, n);
            end
      // R3: cap below computed count
      init_mem(); mem[16'h080] = 8'h05;
      w0 = wr_cnt; d0 = done_cnt;
      arm(mk(16'h0080, 16'h0240, 3'd1, 13'd4, 1'b0, 2'd1, 5'd0, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0));
      pulse_sw(); wait_done(d0);
      check(wr_cnt - w0 == 4, "R3", "length cap", wr_cnt - w0, 4);

      // R6: wrap at 0xFFFF
      r0 = rd_cnt; d0 = done_cnt;
      rd_cnt = 0;
      arm(mk(16'hFFFF, 16'h0240, 3'd0, 13'd2, 1'b0, 2'd1, 5'd0, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0));
      pulse_sw(); wait_done(d0);
      check(rd_log[0] == 16'hFFFF && rd_log[1] == 16'h0000, "R6", "wrap second read",
            rd_log[1], 0);

      // R7 R8 R10: single mode
      w0 = wr_cnt; d0 = done_cnt;
      arm(mk(16'h0080, 16'h0240, 3'd0, 13'd3, 1'b0, 2'd0, 5'd0, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0));
      pulse_sw(); idle(4);
      check(wr_cnt - w0 == 1 && armed_o, "R7", "single one unit", wr_cnt - w0, 1);
      pulse_sw(); idle(4); pulse_sw(); idle(4);
      check(done_cnt - d0 == 1 && wr_cnt - w0 == 3, "R7", "single completes", wr_cnt - w0, 3);
      check(!armed_o, "R8", "one-shot disarms", armed_o, 0);
      w0 = wr_cnt; r0 = rd_cnt;
      pulse_sw(); idle(4);
      check(wr_cnt == w0 && rd_cnt == r0, "R10", "unarmed trigger ignored", rd_cnt - r0, 0);

      // R8: repeated single, reload of addresses
      d0 = done_cnt;
      arm(mk(16'h0080, 16'h0250, 3'd0, 13'd2, 1'b0, 2'd2, 5'd0, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0));
      pulse_sw(); idle(4); pulse_sw(); idle(4);
      check(done_cnt - d0 == 1 && armed_o, "R8", "repeated stays armed", armed_o, 1);
      pulse_sw(); idle(4);
      check(last_wr_addr == 16'h0250, "R8", "address reloaded", last_wr_addr, 16'h0250);

      // R9: trigger selection, repeated block
      d0 = done_cnt; w0 = wr_cnt;
      arm(mk(16'h0080, 16'h0240, 3'd0, 13'd2, 1'b0, 2'd3, 5'd7, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0));
      pulse_line(7); idle(8);
      check(done_cnt - d0 == 1 && wr_cnt - w0 == 2 && armed_o, "R9", "selected line",
            wr_cnt - w0, 2);
      w0 = wr_cnt;
      pulse_line(6); pulse_sw(); idle(6);
      check(wr_cnt == w0, "R9", "unselected lines ignored", wr_cnt - w0, 0);
      d0 = done_cnt; w0 = wr_cnt;
      arm(mk(16'h0080, 16'h0240, 3'd0, 13'd1, 1'b0, 2'd1, 5'd1, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0));
      pulse_line(1); idle(6);
      check(done_cnt - d0 == 1 && wr_cnt - w0 == 1, "R9", "previous-channel line",
            wr_cnt - w0, 1);

      // R11 R12: zero length and interrupt masking
      d0 = done_cnt; i0 = irq_cnt; r0 = rd_cnt;
      arm(mk(16'h0080, 16'h0240, 3'd0, 13'd0, 1'b0, 2'd1, 5'd0, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0));
      pulse_sw(); idle(4);
      check(done_cnt - d0 == 1 && rd_cnt == r0, "R11", "zero count no bus", rd_cnt - r0, 0);
      check(irq_cnt - i0 == 1, "R12", "irq enabled", irq_cnt - i0, 1);
      d0 = done_cnt; i0 = irq_cnt;
      arm(mk(16'h0080, 16'h0240, 3'd1, 13'd0, 1'b0, 2'd1, 5'd0, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0));
      pulse_sw(); idle(4);
      check(done_cnt - d0 == 1 && irq_cnt == i0, "R12", "irq masked", irq_cnt - i0, 0);

      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end
endmodule